// File: doc/BRIEF.md
# Multichannel Tagged Serial Output Framer

The framer receives one conversion result per channel for four channels at once, on a parallel strobe interface. It turns each result into a 32-bit tagged word and shifts the four words out, one after another, on a serial data line. Each word carries three things besides the result. The channel number and a three-bit device address set by strap pins together form a five-bit system-wide address. A flag bit records the state of an external validity input at the moment the samples were taken.

Bit timing comes from a serial clock that an external master provides. A data-ready output tells the master that a set of words is waiting, and a frame-sync output marks the words while they are on the line. Several framers can share one serial line. A token enters on the cascade input, and a device sends only while it holds the token. After its last bit it passes the token on through its cascade output. When a device does not hold the line, its serial output is released (high impedance).

Top module: `tagged_serial_framer`

## Requirements
- R1: While and right after reset: drdy_n=1, fs_n=1, casc_out=0, sdo_oe=0.
- R2: A smp_stb pulse while the block is idle (drdy_n=1 and casc_out=0) latches all four samples, smp_flag and dev_addr, and drdy_n is low on the next clock.
- R3: Each word is laid out as bits [31:10] = sample (twos complement), [9:8] = channel number 0..3, [7:5] = dev_addr, [4] = flag, [3:0] = 0.
- R4: Bits go out MSB first. Channels follow in the order 0,1,2,3, back to back. One bit is sent per falling edge of ser_clk. fs_n, casc_out and sdo_oe change only on a falling edge of ser_clk.
- R5: Sending begins only on a falling edge of ser_clk while casc_in=1 and data is pending. With casc_in=0, sdo_oe stays 0.
- R6: fs_n is 0 for every one of the 128 bits sent and 1 at all other times.
- R7: drdy_n returns to 1 on the falling edge of ser_clk that ends the last bit of channel 3.
- R8: casc_out is 1 for exactly one ser_clk period, starting on the falling edge that ends the last bit.
- R9: sdo_oe is 1 only while bits are being sent. Otherwise sdo is high impedance.
- R10: A smp_stb pulse is ignored while data is pending, while words are being sent and while the token is being handed on.
- R11: The flag and the device address in the words are the values latched at the strobe. Later changes of smp_flag or dev_addr do not affect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe that presents a new set of samples |
| smp_data | input | 88 | Four 22-bit samples, channel k at bits [22k+21:22k] |
| smp_flag | input | 1 | Validity flag, sampled at the strobe |
| dev_addr | input | 3 | Strapped device address |
| ser_clk | input | 1 | Serial bit clock from the master, synchronous to clk, idles high |
| casc_in | input | 1 | Cascade token in |
| sdo | output | 1 | Serial data, high impedance when the line is not held |
| sdo_oe | output | 1 | High while sdo is driven |
| fs_n | output | 1 | Frame sync, low while words are sent |
| drdy_n | output | 1 | Data ready, low while a set of words is pending or being sent |
| casc_out | output | 1 | Cascade token out |

## Verification
The assertions take for granted that ser_clk is a level already synchronous to clk. Each level of ser_clk must last at least one clk period, so that every falling edge is seen exactly once. They also take for granted that smp_stb is a pulse of a single clock cycle. The bench changes ser_clk only on the falling edge of clk and holds each phase for three clock cycles. It drives smp_stb for exactly one cycle, so the stimulus stays inside these assumptions, and the sampled outputs are stable whenever they are read.

// File: rtl/fw_pkg.sv
package fw_pkg;
    localparam int NCH   = 4;
    localparam int DW    = 22;
    localparam int DEVW  = 3;
    localparam int WORDW = 32;
    localparam int CHW   = $clog2(NCH);
    localparam int BW    = $clog2(WORDW);
    localparam int PADW  = WORDW - DW - CHW - DEVW - 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_SEND  = 2'd2,
        ST_PASS  = 2'd3
    } fw_state_e;

    typedef struct packed {
        logic [DW-1:0]   data;
        logic [CHW-1:0]  chan;
        logic [DEVW-1:0] dev;
        logic            flag;
        logic [PADW-1:0] pad;
    } fw_word_t;

    function automatic fw_word_t pack_word(input logic [DW-1:0] d,
                                           input logic [CHW-1:0] ch,
                                           input logic [DEVW-1:0] dv,
                                           input logic fl);
        fw_word_t w;
        w.data = d;
        w.chan = ch;
        w.dev  = dv;
        w.flag = fl;
        w.pad  = '0;
        return w;
    endfunction
endpackage

// File: rtl/fw_edge_detect.sv
module fw_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    output logic fall
);
    logic ser_q;

    always_ff @(posedge clk) begin
        if (rst) ser_q <= 1'b1;
        else     ser_q <= ser_clk;
    end

    assign fall = ser_q & ~ser_clk;
endmodule

// File: rtl/fw_sample_bank.sv
module fw_sample_bank
    import fw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cap,
    input  logic [NCH*DW-1:0]   smp_data,
    input  logic                smp_flag,
    input  logic [DEVW-1:0]     dev_addr,
    output logic [DW-1:0]       data_q [NCH],
    output logic                flag_q,
    output logic [DEVW-1:0]     dev_q
);
    for (genvar k = 0; k < NCH; k++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst)      data_q[k] <= '0;
            else if (cap) data_q[k] <= smp_data[k*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            dev_q  <= '0;
        end else if (cap) begin
            flag_q <= smp_flag;
            dev_q  <= dev_addr;
        end
    end
endmodule

// File: rtl/fw_seq.sv
module fw_seq
    import fw_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           smp_stb,
    input  logic           fall,
    input  logic           casc_in,
    output logic           cap,
    output logic [CHW-1:0] word_idx,
    output logic [BW-1:0]  bit_idx,
    output logic           drdy_n,
    output logic           fs_n,
    output logic           casc_out,
    output logic           sdo_oe
);
    localparam logic [BW-1:0]  LAST_BIT  = BW'(WORDW - 1);
    localparam logic [CHW-1:0] LAST_WORD = CHW'(NCH - 1);

    fw_state_e state;

    assign cap = smp_stb && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            word_idx <= '0;
            bit_idx  <= LAST_BIT;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cap) state <= ST_READY;
                end
                ST_READY: begin
                    if (fall && casc_in) begin
                        state    <= ST_SEND;
                        word_idx <= '0;
                        bit_idx  <= LAST_BIT;
                    end
                end
                ST_SEND: begin
                    if (fall) begin
                        if (bit_idx == '0) begin
                            bit_idx <= LAST_BIT;
                            if (word_idx == LAST_WORD) state <= ST_PASS;
                            else word_idx <= word_idx + 1'b1;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                        end
                    end
                end
                ST_PASS: begin
                    if (fall) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign drdy_n   = !((state == ST_READY) || (state == ST_SEND));
    assign fs_n     = (state != ST_SEND);
    assign sdo_oe   = (state == ST_SEND);
    assign casc_out = (state == ST_PASS);
endmodule

// File: rtl/fw_bit_select.sv
module fw_bit_select
    import fw_pkg::*;
(
    input  logic [DW-1:0]   data_q [NCH],
    input  logic            flag_q,
    input  logic [DEVW-1:0] dev_q,
    input  logic [CHW-1:0]  word_idx,
    input  logic [BW-1:0]   bit_idx,
    output logic            bit_out
);
    logic [WORDW-1:0] words [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_word
        assign words[k] = pack_word(data_q[k], CHW'(k), dev_q, flag_q);
    end

    assign bit_out = words[word_idx][bit_idx];
endmodule

// File: rtl/tagged_serial_framer.sv
module tagged_serial_framer
    import fw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_stb,
    input  logic [NCH*DW-1:0]   smp_data,
    input  logic                smp_flag,
    input  logic [DEVW-1:0]     dev_addr,
    input  logic                ser_clk,
    input  logic                casc_in,
    output logic                sdo,
    output logic                sdo_oe,
    output logic                fs_n,
    output logic                drdy_n,
    output logic                casc_out
);
    logic            fall;
    logic            cap;
    logic [DW-1:0]   data_q [NCH];
    logic            flag_q;
    logic [DEVW-1:0] dev_q;
    logic [CHW-1:0]  word_idx;
    logic [BW-1:0]   bit_idx;
    logic            bit_out;

    fw_edge_detect u_edge (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .fall(fall)
    );

    fw_seq u_seq (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .fall(fall),
        .casc_in(casc_in), .cap(cap), .word_idx(word_idx),
        .bit_idx(bit_idx), .drdy_n(drdy_n), .fs_n(fs_n),
        .casc_out(casc_out), .sdo_oe(sdo_oe)
    );

    fw_sample_bank u_bank (
        .clk(clk), .rst(rst), .cap(cap), .smp_data(smp_data),
        .smp_flag(smp_flag), .dev_addr(dev_addr),
        .data_q(data_q), .flag_q(flag_q), .dev_q(dev_q)
    );

    fw_bit_select u_sel (
        .data_q(data_q), .flag_q(flag_q), .dev_q(dev_q),
        .word_idx(word_idx), .bit_idx(bit_idx), .bit_out(bit_out)
    );

    assign sdo = sdo_oe ? bit_out : 1'bz;
endmodule

// File: rtl/fw_checker.sv
module fw_checker (
    input logic clk,
    input logic rst,
    input logic smp_stb,
    input logic ser_clk,
    input logic casc_in,
    input logic sdo_oe,
    input logic fs_n,
    input logic drdy_n,
    input logic casc_out
);
    logic ser_q;
    always_ff @(posedge clk) begin
        if (rst) ser_q <= 1'b1;
        else     ser_q <= ser_clk;
    end

    assert_idle_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && drdy_n && !casc_out) |=> !drdy_n);

    assert_outputs_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (ser_clk || !ser_q) |=> ($stable(fs_n) && $stable(casc_out) && $stable(sdo_oe)));

    assert_start_needs_token_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(fs_n) |-> ($past(casc_in) && $past(ser_q) && !$past(ser_clk)));

    assert_release_with_token_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(casc_out) |-> ($rose(drdy_n) && !sdo_oe));

    assert_drive_only_pending_R9: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> !drdy_n);
endmodule

bind tagged_serial_framer fw_checker u_chk (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .ser_clk(ser_clk),
    .casc_in(casc_in), .sdo_oe(sdo_oe), .fs_n(fs_n),
    .drdy_n(drdy_n), .casc_out(casc_out)
);

// File: tb/sim_tagged_serial_framer.sv
module sim_tagged_serial_framer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic [87:0] smp_data = '0;
    logic        smp_flag = 1'b0;
    logic [2:0]  dev_addr = '0;
    logic        ser_clk = 1'b1;
    logic        casc_in = 1'b0;
    logic        sdo, sdo_oe, fs_n, drdy_n, casc_out;

    int n_chk = 0;
    int n_fail = 0;

    logic s_sdo, s_oe, s_fs, s_drdy, s_casc;
    logic [31:0] rxw [4];
    int fs_bad, oe_bad;

    tagged_serial_framer u0 (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_data(smp_data),
        .smp_flag(smp_flag), .dev_addr(dev_addr), .ser_clk(ser_clk),
        .casc_in(casc_in), .sdo(sdo), .sdo_oe(sdo_oe), .fs_n(fs_n),
        .drdy_n(drdy_n), .casc_out(casc_out)
    );

    always #5 clk = ~clk;

    localparam int NV = 3;
    localparam logic [21:0] VD [NV][4] = '{
        '{22'h1FFFFF, 22'h200000, 22'h3FFFFF, 22'h000000},
        '{22'h2AAAAA, 22'h155555, 22'h000001, 22'h300F0F},
        '{22'h123456, 22'h0ABCDE, 22'h3C0003, 22'h1E1E1E}
    };
    localparam logic [2:0] VDEV [NV] = '{3'd0, 3'd7, 3'd5};
    localparam logic       VFLG [NV] = '{1'b0, 1'b1, 1'b1};

    function automatic logic [31:0] exp_word(input logic [21:0] d, input int ch,
                                             input logic [2:0] dv, input logic fl);
        return {d, 2'(ch), dv, fl, 4'b0000};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [21:0] d [4], input logic [2:0] dv, input logic fl);
        @(negedge clk);
        for (int k = 0; k < 4; k++) smp_data[k*22 +: 22] = d[k];
        dev_addr = dv;
        smp_flag = fl;
        smp_stb  = 1'b1;
        @(negedge clk);
        smp_stb  = 1'b0;
    endtask

    task automatic ser_cycle();
        @(negedge clk);
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        s_sdo = sdo; s_oe = sdo_oe; s_fs = fs_n; s_drdy = drdy_n; s_casc = casc_out;
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // 128 bit periods; optional mid-transfer strobe with other data (R10)
    task automatic xfer(input bit poke, input logic [21:0] pd [4]);
        fs_bad = 0; oe_bad = 0;
        casc_in = 1'b1;
        for (int i = 0; i < 128; i++) begin
            ser_cycle();
            rxw[i/32] = {rxw[i/32][30:0], s_sdo};
            if (s_fs) fs_bad++;
            if (!s_oe) oe_bad++;
            if (poke && i == 40) strobe(pd, 3'd2, 1'b0);
        end
        casc_in = 1'b0;
    endtask

    task automatic check_words(input logic [21:0] d [4], input logic [2:0] dv,
                               input logic fl, input string req);
        for (int k = 0; k < 4; k++)
            chk(rxw[k] == exp_word(d[k], k, dv, fl), req, rxw[k], exp_word(d[k], k, dv, fl));
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [21:0] cur [4];
        logic [21:0] alt [4];
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(drdy_n && fs_n && !casc_out && !sdo_oe, "R1 during reset",
            {drdy_n, fs_n, casc_out, sdo_oe}, 32'b1100);
        rst = 1'b0;
        @(negedge clk);
        chk(drdy_n && fs_n && !casc_out && !sdo_oe, "R1 after reset",
            {drdy_n, fs_n, casc_out, sdo_oe}, 32'b1100);

        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 4; k++) cur[k] = VD[v][k];
            strobe(cur, VDEV[v], VFLG[v]);
            chk(drdy_n == 1'b0, "R2 drdy_n low after capture", drdy_n, 0);
            if (v == 0) begin
                // R5: no token, nothing sent
                ser_cycle();
                ser_cycle();
                chk(!s_oe && s_fs, "R5 no start without casc_in", {s_oe, s_fs}, 32'b01);
                // R10: strobe while pending is ignored
                for (int k = 0; k < 4; k++) alt[k] = ~cur[k];
                strobe(alt, 3'd6, 1'b1);
            end
            if (v == 1) begin
                // R11: inputs change after capture
                smp_flag = 1'b0;
                dev_addr = 3'd1;
            end
            for (int k = 0; k < 4; k++) alt[k] = cur[k] ^ 22'h0F0F0F;
            xfer(v == 2, alt);
            check_words(cur, VDEV[v], VFLG[v],
                        v == 0 ? "R3 R4 R10 word" : (v == 1 ? "R3 R4 R11 word" : "R3 R4 R10 mid-send"));
            chk(fs_bad == 0, "R6 fs_n low every bit", fs_bad, 0);
            chk(oe_bad == 0, "R9 sdo_oe high every bit", oe_bad, 0);
            ser_cycle();
            chk(s_drdy == 1'b1, "R7 drdy_n high after last bit", s_drdy, 1);
            chk(s_casc == 1'b1 && !s_oe && s_fs, "R8 R9 R6 token out, line released",
                {s_casc, s_oe, s_fs}, 32'b101);
            if (v == 2) begin
                // R10: strobe during token hand-over ignored
                strobe(alt, 3'd3, 1'b1);
                chk(drdy_n == 1'b1, "R10 strobe ignored while passing", drdy_n, 1);
            end
            ser_cycle();
            chk(s_casc == 1'b0 && s_drdy, "R8 token out one period", {s_casc, s_drdy}, 32'b01);
        end

        // R10 continued: after the ignored strobe, another transfer has nothing pending
        casc_in = 1'b1;
        ser_cycle();
        chk(!s_oe && s_drdy, "R10 no data after ignored strobe", {s_oe, s_drdy}, 32'b01);
        casc_in = 1'b0;

        // R1: reset mid-send returns to idle
        for (int k = 0; k < 4; k++) cur[k] = VD[0][k];
        strobe(cur, 3'd4, 1'b1);
        casc_in = 1'b1;
        ser_cycle();
        chk(s_oe == 1'b1, "R5 start with casc_in", s_oe, 1);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(drdy_n && fs_n && !casc_out && !sdo_oe, "R1 reset while sending",
            {drdy_n, fs_n, casc_out, sdo_oe}, 32'b1100);
        casc_in = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule